// File: doc/BRIEF.md
# Three-Channel Match and Wrap Timer

This block is a register-mapped timer holding three independent counters. Each counter has its own reload value and two compare values. A shared control register turns each counter on or off, picks its stepping source and its direction, and gates its interrupt. A counter either steps on every clock, or steps only on cycles where the `tick_en` input is high. When a counter steps past its end value, it wraps to its reload value. Counting up, the end value is all ones. Counting down, the end value is zero. A wrap, or a step that lands on a compare value, raises a sticky flag in a shared status register.

Software clears a flag by writing a one to it. A mask register and each channel's interrupt-enable bit decide which flags drive the single interrupt line. There are two typical uses. For a periodic tick, count up from an all-ones-minus-(P-1) reload and take the wrap event, which occurs every P steps. For a one-shot event, program a compare value some distance ahead of the running count.

The bus is a simple single-cycle register port. Writes take effect at the clock edge. Read data is a combinational function of the selected address and carries no side effects.

Top module: `triple_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Channel c (c = 0..2) has its count at byte address 16c, its reload at 16c+4, compare A at 16c+8 and compare B at 16c+12. Control is at 0x30, flags at 0x34 and mask at 0x38. Every register reads back what was written, with control limited to 12 bits and flags and mask limited to 9 bits. Any other address, including a misaligned one, reads zero.
- R3: In the control register, channel c uses bit 3c for run, bit 3c+1 for stepping source and bit 3c+2 for interrupt enable. Bit 9+c set selects up-counting for channel c; clear selects down-counting.
- R4: When the source bit is clear, a running channel steps on every clock. When it is set, the channel steps only on clocks where `tick_en` is high.
- R5: Counting up, a step increments the count. A step from 0xFFFFFFFF loads the reload value instead and sets flag 3c+2.
- R6: Counting down, a step decrements the count. A step from 0 loads the reload value instead and sets flag 3c+2.
- R7: In either direction, a step whose new count equals compare A sets flag 3c. A step whose new count equals compare B sets flag 3c+1.
- R8: A channel whose run bit is clear holds its count. A bus write to a count register replaces the value, and no step or event occurs for that channel in that cycle.
- R9: Flags stay set until a bus write to 0x34 with a one in that bit position. An event in the same cycle as the clear leaves the flag set.
- R10: `irq` is high exactly when some flag bit 3c+k is set, its mask bit 3c+k is set and channel c's interrupt-enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| tick_en | input | 1 | External step qualifier for channels using the tick source |
| irq | output | 1 | Combined interrupt request |

## Verification
The wrap assertions assume that the register being checked is not written in the cycle of the wrap. They also assume that reset is only asserted asynchronously and released between clock edges. The bench honours both assumptions, because every bus access and every change of `tick_en` is driven one nanosecond after a clock edge. The flag-retention assertion treats any write to 0x34 as a possible clear, so the bench is free to issue clears while events are arriving. Beyond that, the bench places no limits on the values or the timing of its writes.

// File: rtl/triple_timer_pkg.sv
package triple_timer_pkg;
  localparam int NCH     = 3;
  localparam int EVW     = 3 * NCH;
  localparam int CTRL_W  = 4 * NCH;
  localparam int ADDR_W  = 6;
  localparam int EV_CMPA = 0;
  localparam int EV_CMPB = 1;
  localparam int EV_WRAP = 2;
  localparam int UP_BASE = 3 * NCH;
endpackage

// File: rtl/tt_channel.sv
module tt_channel #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          count_up,
  input  logic          wr_cnt,
  input  logic          wr_load,
  input  logic          wr_cmpa,
  input  logic          wr_cmpb,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt_q,
  output logic [DW-1:0] load_q,
  output logic [DW-1:0] cmpa_q,
  output logic [DW-1:0] cmpb_q,
  output logic [2:0]    ev
);
  import triple_timer_pkg::*;

  logic          at_end;
  logic          adv;
  logic [DW-1:0] stepped;
  logic [DW-1:0] cnt_d;

  always_comb begin
    at_end  = count_up ? (cnt_q == {DW{1'b1}}) : (cnt_q == '0);
    adv     = step && !wr_cnt;
    if (at_end)        stepped = load_q;
    else if (count_up) stepped = cnt_q + 1'b1;
    else               stepped = cnt_q - 1'b1;
    if (wr_cnt)        cnt_d = wdata;
    else if (step)     cnt_d = stepped;
    else               cnt_d = cnt_q;
    ev          = '0;
    ev[EV_WRAP] = adv && at_end;
    ev[EV_CMPA] = adv && (stepped == cmpa_q);
    ev[EV_CMPB] = adv && (stepped == cmpb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (wr_cnt || step) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) load_q <= '0;
    else if (wr_load) load_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmpa_q <= '0;
    else if (wr_cmpa) cmpa_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmpb_q <= '0;
    else if (wr_cmpb) cmpb_q <= wdata;
  end
endmodule

// File: rtl/tt_irq.sv
module tt_irq
  import triple_timer_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EVW-1:0] ev_set,
  input  logic           wr_clear,
  input  logic           wr_mask,
  input  logic [EVW-1:0] wdata,
  input  logic [NCH-1:0] ch_ie,
  output logic [EVW-1:0] flags_q,
  output logic [EVW-1:0] mask_q,
  output logic           irq
);
  logic [EVW-1:0] flags_d;
  logic [EVW-1:0] ie_wide;

  always_comb begin
    flags_d = (flags_q & ~(wr_clear ? wdata : '0)) | ev_set;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ie
    assign ie_wide[3*c +: 3] = {3{ch_ie[c]}};
  end

  assign irq = |(flags_q & mask_q & ie_wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else if (wr_clear || (|ev_set)) flags_q <= flags_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (wr_mask) mask_q <= wdata;
  end
endmodule

// File: rtl/triple_timer.sv
module triple_timer #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [5:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_en,
  output logic          irq
);
  import triple_timer_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h30;
  localparam logic [ADDR_W-1:0] A_FLAGS = 6'h34;
  localparam logic [ADDR_W-1:0] A_MASK  = 6'h38;

  logic                    wr_any;
  logic [CTRL_W-1:0]       ctrl_q;
  logic [NCH-1:0][DW-1:0]  cnt_all;
  logic [NCH-1:0][DW-1:0]  load_all;
  logic [NCH-1:0][DW-1:0]  cmpa_all;
  logic [NCH-1:0][DW-1:0]  cmpb_all;
  logic [EVW-1:0]          ev_all;
  logic [EVW-1:0]          status_q;
  logic [EVW-1:0]          mask_q;
  logic [NCH-1:0]          ch_ie;

  assign wr_any = bus_sel && bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_any && bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(16 * c);
    logic step;
    assign ch_ie[c] = ctrl_q[3*c+2];
    assign step = ctrl_q[3*c] && (!ctrl_q[3*c+1] || tick_en);

    tt_channel #(.DW(DW)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .count_up(ctrl_q[UP_BASE+c]),
      .wr_cnt  (wr_any && bus_addr == BASE),
      .wr_load (wr_any && bus_addr == BASE + 6'd4),
      .wr_cmpa (wr_any && bus_addr == BASE + 6'd8),
      .wr_cmpb (wr_any && bus_addr == BASE + 6'd12),
      .wdata   (bus_wdata),
      .cnt_q   (cnt_all[c]),
      .load_q  (load_all[c]),
      .cmpa_q  (cmpa_all[c]),
      .cmpb_q  (cmpb_all[c]),
      .ev      (ev_all[3*c +: 3])
    );
  end

  tt_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev_set  (ev_all),
    .wr_clear(wr_any && bus_addr == A_FLAGS),
    .wr_mask (wr_any && bus_addr == A_MASK),
    .wdata   (bus_wdata[EVW-1:0]),
    .ch_ie   (ch_ie),
    .flags_q (status_q),
    .mask_q  (mask_q),
    .irq     (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr[1:0] == 2'b00) begin
      if (int'(bus_addr[5:4]) < NCH) begin
        case (bus_addr[3:2])
          2'd0:    bus_rdata = cnt_all[bus_addr[5:4]];
          2'd1:    bus_rdata = load_all[bus_addr[5:4]];
          2'd2:    bus_rdata = cmpa_all[bus_addr[5:4]];
          default: bus_rdata = cmpb_all[bus_addr[5:4]];
        endcase
      end else begin
        case (bus_addr[3:2])
          2'd0:    bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_q};
          2'd1:    bus_rdata = {{(DW-EVW){1'b0}}, status_q};
          2'd2:    bus_rdata = {{(DW-EVW){1'b0}}, mask_q};
          default: bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/triple_timer_chk.sv
module triple_timer_chk
  import triple_timer_pkg::*;
#(
  parameter int DW = 32
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [5:0]             bus_addr,
  input logic                   tick_en,
  input logic                   irq,
  input logic [CTRL_W-1:0]      ctrl_q,
  input logic [EVW-1:0]         status_q,
  input logic [EVW-1:0]         mask_q,
  input logic [NCH-1:0][DW-1:0] cnt_q,
  input logic [NCH-1:0][DW-1:0] load_q
);
  logic [EVW-1:0] ie_wide;
  logic           clr_wr;

  assign clr_wr = bus_sel && bus_wr && bus_addr == 6'h34;

  for (genvar c = 0; c < NCH; c++) begin : g_c
    logic cnt_wr;
    logic ld_wr;
    logic adv;
    assign ie_wide[3*c +: 3] = {3{ctrl_q[3*c+2]}};
    assign cnt_wr = bus_sel && bus_wr && bus_addr == 6'(16*c);
    assign ld_wr  = bus_sel && bus_wr && bus_addr == 6'(16*c+4);
    assign adv    = ctrl_q[3*c] && (!ctrl_q[3*c+1] || tick_en) && !cnt_wr;

    assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[3*c] && !cnt_wr) |=> $stable(cnt_q[c]));

    assert_up_wrap_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && ctrl_q[UP_BASE+c] && cnt_q[c] == {DW{1'b1}} && !ld_wr)
      |=> (cnt_q[c] == $past(load_q[c]) && status_q[3*c+2]));

    assert_down_wrap_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !ctrl_q[UP_BASE+c] && cnt_q[c] == '0 && !ld_wr)
      |=> (cnt_q[c] == $past(load_q[c]) && status_q[3*c+2]));
  end

  assert_flags_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> |(status_q & mask_q & ie_wide));

  assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind triple_timer triple_timer_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bus_sel (bus_sel),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .tick_en (tick_en),
  .irq     (irq),
  .ctrl_q  (ctrl_q),
  .status_q(status_q),
  .mask_q  (mask_q),
  .cnt_q   (cnt_all),
  .load_q  (load_all)
);

// File: tb/triple_timer_test.sv
module triple_timer_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0;
  logic        bus_wr = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        tick_en = 0;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  triple_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq(irq)
  );

  always #10 clk = ~clk;

  // behavioural reference state
  logic [31:0] m_cnt [3];
  logic [31:0] m_load[3];
  logic [31:0] m_ca  [3];
  logic [31:0] m_cb  [3];
  logic [11:0] m_ctrl;
  logic [8:0]  m_flag;
  logic [8:0]  m_mask;
  logic [31:0] nxt   [3];
  logic [8:0]  evs;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) begin
        m_cnt[i] = 0; m_load[i] = 0; m_ca[i] = 0; m_cb[i] = 0;
      end
      m_ctrl = 0; m_flag = 0; m_mask = 0;
    end else begin
      evs = 0;
      for (int i = 0; i < 3; i++) begin
        bit run, moves, up;
        run   = m_ctrl[3*i];
        moves = run && (!m_ctrl[3*i+1] || tick_en);
        up    = m_ctrl[9+i];
        nxt[i] = m_cnt[i];
        if (bus_sel && bus_wr && bus_addr == 6'(16*i)) begin
          nxt[i] = bus_wdata;
        end else if (moves) begin
          if (up && m_cnt[i] == 32'hFFFF_FFFF) begin
            nxt[i] = m_load[i]; evs[3*i+2] = 1;
          end else if (!up && m_cnt[i] == 0) begin
            nxt[i] = m_load[i]; evs[3*i+2] = 1;
          end else begin
            nxt[i] = up ? m_cnt[i] + 1 : m_cnt[i] - 1;
          end
          if (nxt[i] == m_ca[i]) evs[3*i]   = 1;
          if (nxt[i] == m_cb[i]) evs[3*i+1] = 1;
        end
      end
      if (bus_sel && bus_wr && bus_addr == 6'h34) m_flag = m_flag & ~bus_wdata[8:0];
      m_flag = m_flag | evs;
      if (bus_sel && bus_wr) begin
        for (int i = 0; i < 3; i++) begin
          if (bus_addr == 6'(16*i+4))  m_load[i] = bus_wdata;
          if (bus_addr == 6'(16*i+8))  m_ca[i]   = bus_wdata;
          if (bus_addr == 6'(16*i+12)) m_cb[i]   = bus_wdata;
        end
        if (bus_addr == 6'h30) m_ctrl = bus_wdata[11:0];
        if (bus_addr == 6'h38) m_mask = bus_wdata[8:0];
      end
      for (int i = 0; i < 3; i++) m_cnt[i] = nxt[i];
    end
  end

  function automatic logic [31:0] m_read(input logic [5:0] a);
    if (a[1:0] != 0) return 0;
    if (a < 6'h30) begin
      case (a[3:2])
        2'd0: return m_cnt[a[5:4]];
        2'd1: return m_load[a[5:4]];
        2'd2: return m_ca[a[5:4]];
        default: return m_cb[a[5:4]];
      endcase
    end
    if (a == 6'h30) return {20'd0, m_ctrl};
    if (a == 6'h34) return {23'd0, m_flag};
    if (a == 6'h38) return {23'd0, m_mask};
    return 0;
  endfunction

  function automatic logic m_irq();
    logic r = 0;
    for (int i = 0; i < 9; i++)
      if (m_flag[i] && m_mask[i] && m_ctrl[3*(i/3)+2]) r = 1;
    return r;
  endfunction

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  // R10: interrupt line compared against the model every clock
  always @(negedge clk) begin
    if (rst_n) begin
      n_tests++;
      if (irq !== m_irq()) begin
        n_fail++;
        $display("FAIL R10 irq at %0t: got %0b expected %0b", $time, irq, m_irq());
      end
    end
  end

  // external tick pattern: high on two of every five cycles
  int cyc = 0;
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    tick_en = (cyc % 5 == 1) || (cyc % 5 == 3);
  end

  task automatic bwrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic [5:0] a, input string tag);
    logic [31:0] exp;
    @(negedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #2;
    exp = m_read(a);
    n_tests++;
    if (bus_rdata !== exp) begin
      n_fail++;
      $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
    end
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values
    for (int a = 0; a < 64; a += 4) bread(6'(a), "R1");
    n_tests++;
    if (irq !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 irq after reset: got %0b expected 0", irq);
    end

    // R2: map and readback with all channels stopped
    for (int i = 0; i < 3; i++) begin
      bwrite(6'(16*i),    32'h1000_0000 + i);
      bwrite(6'(16*i+4),  32'h2000_0000 + i);
      bwrite(6'(16*i+8),  32'h3000_0000 + i);
      bwrite(6'(16*i+12), 32'h4000_0000 + i);
    end
    bwrite(6'h38, 32'hFFFF_FFFF);
    bwrite(6'h30, 32'hFFFF_F000);
    for (int a = 0; a < 64; a += 4) bread(6'(a), "R2");
    bread(6'h01, "R2");
    bread(6'h22, "R2");
    bread(6'h3C, "R2");

    // R3/R5: channel 0 up, period 5 via wrap
    bwrite(6'h04, 32'hFFFF_FFFB);
    bwrite(6'h00, 32'hFFFF_FFFB);
    bwrite(6'h08, 32'hFFFF_FFFD);
    bwrite(6'h0C, 32'h5555_5555);
    bwrite(6'h30, 32'h0000_0205);
    bread(6'h30, "R3");
    for (int k = 0; k < 12; k++) bread(6'h00, "R5");
    bread(6'h34, "R5");
    bread(6'h34, "R7");

    // R9: clears while wrap/compare events keep arriving
    for (int k = 0; k < 8; k++) begin
      bwrite(6'h34, 32'h0000_01FF);
      bread(6'h34, "R9");
    end
    bwrite(6'h30, 32'h0);
    bwrite(6'h34, 32'h0000_01FF);
    bread(6'h34, "R9");
    idle(4);
    bread(6'h34, "R9");

    // R6/R7: channel 1 down, reload 3, compare A 0, compare B 2
    bwrite(6'h14, 32'd3);
    bwrite(6'h10, 32'd3);
    bwrite(6'h18, 32'd0);
    bwrite(6'h1C, 32'd2);
    bwrite(6'h30, 32'h0000_0028);
    for (int k = 0; k < 12; k++) bread(6'h10, "R6");
    bread(6'h34, "R7");

    // R4: channel 2 up on tick source
    bwrite(6'h24, 32'd0);
    bwrite(6'h20, 32'd0);
    bwrite(6'h28, 32'd4);
    bwrite(6'h2C, 32'd7);
    bwrite(6'h30, 32'h0000_09E8);
    for (int k = 0; k < 20; k++) bread(6'h20, "R4");
    bread(6'h34, "R7");

    // R8: stop channel 2, count must hold; write count while channel 1 runs
    bwrite(6'h30, 32'h0000_0028);
    for (int k = 0; k < 5; k++) bread(6'h20, "R8");
    bwrite(6'h10, 32'd2);
    bread(6'h10, "R8");
    bwrite(6'h10, 32'd0);
    bread(6'h10, "R8");
    bread(6'h34, "R8");

    // R10: gating by mask and per-channel enable
    bwrite(6'h34, 32'h0000_01FF);
    bwrite(6'h38, 32'h0000_0008);
    idle(10);
    bwrite(6'h30, 32'h0000_0008);
    idle(10);
    bwrite(6'h38, 32'h0);
    bwrite(6'h30, 32'h0000_0028);
    idle(10);
    bread(6'h34, "R10");
    bread(6'h38, "R10");

    idle(2);
    summary();
    $finish;
  end
endmodule